// File: doc/BRIEF.md
# Peripheral Clock Enable Controller

This block sits in front of one peripheral and decides when its core may run. It owns a single control register. That register has a shut-off request bit, a read-only "module off" status bit, a bit that lets the module keep running through sleep, and a bit that lets debug suspend halt the module. It also holds an 8-bit run-mode divider. From these the block produces a one-cycle clock-enable pulse for the peripheral core, once every divider-value cycles, while the module is on and neither sleep nor suspend holds it.

Every bus access to the peripheral's register window passes through the block. Writes to registers other than the control register are refused with a bus error while the module is off or still turning on. Forwarded writes and read side effects are only passed to the core while it is on. Reads themselves never fault. A divider value of zero is a second way to switch the module off.

Top module: `pcc_top`

## Requirements
- R1: After reset the status bit (ctrl bit 1) and the shut-off bit (bit 0) read 1, the divider (bits 15:8) reads 1, bits 2 and 3 read 0, and no clock-enable pulse is produced.
- R2: A control write while off and idle that leaves bit 0 at 0 and a nonzero divider keeps the status at 1 for exactly 4 cycles after the write edge, and then the status reads 0.
- R3: While on, a control write with bit 0 set or with divider 0 sets the status on the next cycle, and clock-enable pulses stop.
- R4: While off and not turning on, control writes are accepted without a bus error. Bit 1 of the written data is ignored.
- R5: While the status is 1, a write to any address other than the control register (address 0) raises bus_err and is not forwarded to the core.
- R6: During the 4-cycle turn-on window, every write, including one to the control register, raises bus_err. A control write in that window changes nothing.
- R7: Reads never raise bus_err. The read side-effect enable to the core stays low while the status is 1 and for control-register reads.
- R8: While running, clk_en pulses once every D cycles, where D is the divider value. The first pulse comes in the D-th cycle after the status clears. A divider change takes effect without a stall.
- R9: With bit 3 at 0, an asserted sleep_req stops clk_en. With bit 3 at 1, sleep_req has no effect.
- R10: With bit 2 at 1, an asserted susp_req stops clk_en. With bit 2 at 0, susp_req has no effect.
- R11: While on, writes to non-control addresses are forwarded with no bus error, and reads of them raise the read side-effect enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index within the peripheral window; 0 is the control register |
| bus_wdata | input | 32 | Write data |
| bus_err | output | 1 | Bus error response for the current access |
| core_wr_en | output | 1 | Write forwarded to a core register |
| core_rd_fx_en | output | 1 | Core may apply read side effects for this access |
| ctrl_rdata | output | 32 | Current control register contents |
| sleep_req | input | 1 | System sleep request |
| susp_req | input | 1 | Debug suspend request |
| clk_en | output | 1 | Divided, gated clock enable for the core |
| mod_off | output | 1 | Status: 1 while off or turning on |

## Verification
The assertions assume that bus_valid, bus_we, bus_addr, sleep_req and susp_req are always known values and are held steady from one clock edge to the next. They also assume a bus access lasts exactly one cycle, with no wait states. The bench drives every input at the falling edge and holds it for the whole cycle. It never leaves an input undriven after reset. It issues single-cycle accesses only, so the combinational response and the register update line up with the reference model cycle by cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam int unsigned DIV_W = 8;

    localparam int unsigned B_SHUT  = 0;
    localparam int unsigned B_STAT  = 1;
    localparam int unsigned B_SUSEN = 2;
    localparam int unsigned B_SLPIG = 3;
    localparam int unsigned B_DIVLO = 8;

    typedef struct packed {
        logic             shut;
        logic             slp_ign;
        logic             sus_en;
        logic [DIV_W-1:0] div;
    } ctl_t;

endpackage

// File: rtl/pcc_clkdiv.sv
module pcc_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIV_W:0] next_cnt;

    always_comb begin
        st_d     = st_q;
        next_cnt = {1'b0, st_q.cnt} + 1'b1;
        tick     = run && !clear && (next_cnt >= {1'b0, div});
        if (clear) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = tick ? '0 : next_cnt[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_no_tick_when_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !tick);

endmodule

// File: rtl/pcc_bus_gate.sv
module pcc_bus_gate #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              valid,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              off,
    input  logic              busy,
    output logic              err,
    output logic              core_wr,
    output logic              core_rd_fx,
    output logic              ctl_wr_ok
);

    logic ctl_hit;

    always_comb begin
        ctl_hit    = (addr == '0);
        err        = valid && we && (ctl_hit ? busy : off);
        core_wr    = valid && we && !ctl_hit && !off;
        core_rd_fx = valid && !we && !ctl_hit && !off;
        ctl_wr_ok  = valid && we && ctl_hit && !busy;
    end

    always_comb begin
        a_r7_read_never_faults: assert (!(valid && !we && err));
    end

endmodule

// File: rtl/pcc_top.sv
module pcc_top #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned EN_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_err,
    output logic              core_wr_en,
    output logic              core_rd_fx_en,
    output logic [31:0]       ctrl_rdata,
    input  logic              sleep_req,
    input  logic              susp_req,
    output logic              clk_en,
    output logic              mod_off
);
    import pcc_pkg::*;

    localparam int unsigned DLY_W = $clog2(EN_DLY + 1);

    typedef struct packed {
        ctl_t             ctl;
        logic             off;
        logic [DLY_W-1:0] dly;
    } top_st_t;

    top_st_t st_d, st_q;

    logic busy, ctl_wr_ok, want_on, run;
    logic [DIV_W-1:0] wdiv;

    pcc_bus_gate #(.ADDR_W(ADDR_W)) u_gate (
        .valid      (bus_valid),
        .we         (bus_we),
        .addr       (bus_addr),
        .off        (st_q.off),
        .busy       (busy),
        .err        (bus_err),
        .core_wr    (core_wr_en),
        .core_rd_fx (core_rd_fx_en),
        .ctl_wr_ok  (ctl_wr_ok)
    );

    always_comb begin
        busy    = (st_q.dly != '0);
        wdiv    = bus_wdata[B_DIVLO +: DIV_W];
        want_on = !bus_wdata[B_SHUT] && (wdiv != '0);
        run     = !st_q.off
                  && !(sleep_req && !st_q.ctl.slp_ign)
                  && !(susp_req && st_q.ctl.sus_en);

        st_d = st_q;
        if (ctl_wr_ok) begin
            st_d.ctl.shut    = bus_wdata[B_SHUT];
            st_d.ctl.sus_en  = bus_wdata[B_SUSEN];
            st_d.ctl.slp_ign = bus_wdata[B_SLPIG];
            st_d.ctl.div     = wdiv;
        end
        if (busy) begin
            st_d.dly = st_q.dly - 1'b1;
            if (st_q.dly == DLY_W'(1)) st_d.off = 1'b0;
        end else if (ctl_wr_ok) begin
            if (st_q.off && want_on)       st_d.dly = DLY_W'(EN_DLY);
            else if (!st_q.off && !want_on) st_d.off = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl.shut    <= 1'b1;
            st_q.ctl.slp_ign <= 1'b0;
            st_q.ctl.sus_en  <= 1'b0;
            st_q.ctl.div     <= DIV_W'(1);
            st_q.off         <= 1'b1;
            st_q.dly         <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pcc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st_q.off),
        .run   (run),
        .div   (st_q.ctl.div),
        .tick  (clk_en)
    );

    always_comb begin
        ctrl_rdata                   = '0;
        ctrl_rdata[B_SHUT]           = st_q.ctl.shut;
        ctrl_rdata[B_STAT]           = st_q.off;
        ctrl_rdata[B_SUSEN]          = st_q.ctl.sus_en;
        ctrl_rdata[B_SLPIG]          = st_q.ctl.slp_ign;
        ctrl_rdata[B_DIVLO +: DIV_W] = st_q.ctl.div;
        mod_off                      = st_q.off;
    end

    a_r5_off_write_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr != '0 && mod_off) |-> (bus_err && !core_wr_en));
    a_r6_busy_ctl_write_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && busy) |-> bus_err);
    a_r7_no_rd_fx_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        mod_off |-> !core_rd_fx_en);
    a_r8_no_clk_en_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        mod_off |-> !clk_en);
    a_r2_turn_on_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_off) |-> $past(st_q.dly) == DLY_W'(1));
    a_r3_shut_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_ok && !mod_off && !want_on) |=> mod_off);
    a_r9_sleep_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !ctrl_rdata[B_SLPIG]) |-> !clk_en);
    a_r10_suspend_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_req && ctrl_rdata[B_SUSEN]) |-> !clk_en);

endmodule

// File: tb/sim_pcc_top.sv
`timescale 1ns/1ps
module sim_pcc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        sleep_req = 1'b0, susp_req = 1'b0;
    logic        bus_err, core_wr_en, core_rd_fx_en, clk_en, mod_off;
    logic [31:0] ctrl_rdata;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    pcc_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_err(bus_err),
        .core_wr_en(core_wr_en), .core_rd_fx_en(core_rd_fx_en),
        .ctrl_rdata(ctrl_rdata), .sleep_req(sleep_req), .susp_req(susp_req),
        .clk_en(clk_en), .mod_off(mod_off)
    );

    // behavioural reference state
    bit m_off = 1, m_shut = 1, m_slp_ign = 0, m_sus_en = 0;
    int m_div = 1, m_wait = 0, m_phase = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic cyc(bit v, bit w, logic [3:0] a, logic [31:0] d, bit sl, bit su);
        bit ctl, run, e_err, e_wr, e_rfx, e_ce, acc, on_req;
        logic [31:0] e_rd;
        int nd;
        @(negedge clk);
        bus_valid = v; bus_we = w; bus_addr = a; bus_wdata = d;
        sleep_req = sl; susp_req = su;
        #1;
        ctl   = v && (a == 0);
        e_err = v && w && (ctl ? (m_wait > 0) : m_off);
        e_wr  = v && w && !ctl && !m_off;
        e_rfx = v && !w && !ctl && !m_off;
        run   = !m_off && !(sl && !m_slp_ign) && !(su && m_sus_en);
        e_ce  = run && (m_phase + 1 >= m_div);
        e_rd  = 0;
        e_rd[0] = m_shut; e_rd[1] = m_off; e_rd[2] = m_sus_en; e_rd[3] = m_slp_ign;
        e_rd[15:8] = m_div[7:0];
        chk("bus_err", 32'(bus_err), 32'(e_err));
        chk("core_wr_en", 32'(core_wr_en), 32'(e_wr));
        chk("core_rd_fx_en", 32'(core_rd_fx_en), 32'(e_rfx));
        chk("clk_en", 32'(clk_en), 32'(e_ce));
        chk("mod_off", 32'(mod_off), 32'(m_off));
        chk("ctrl_rdata", ctrl_rdata, e_rd);
        @(posedge clk);
        // reference update
        acc    = v && w && ctl && (m_wait == 0);
        nd     = int'(d[15:8]);
        on_req = !d[0] && nd != 0;
        if (m_off) m_phase = 0;
        else if (run) m_phase = e_ce ? 0 : m_phase + 1;
        if (m_wait > 0) begin
            m_wait--;
            if (m_wait == 0) m_off = 0;
        end else if (acc) begin
            if (m_off && on_req) m_wait = 4;
            else if (!m_off && !on_req) m_off = 1;
        end
        if (acc) begin
            m_shut = d[0]; m_sus_en = d[2]; m_slp_ign = d[3]; m_div = nd;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 4'd0, 32'd0, 0, 0);
    endtask

    initial begin
        #100_000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R1";  idle(3);
        cur_req = "R5";  cyc(1, 1, 4'd4, 32'h1234, 0, 0);
        cur_req = "R7";  cyc(1, 0, 4'd4, 0, 0, 0); cyc(1, 0, 4'd0, 0, 0, 0);
        cur_req = "R4";  cyc(1, 1, 4'd0, 32'h0000_0303, 0, 0); idle(2);
        cur_req = "R2";  cyc(1, 1, 4'd0, 32'h0000_0300, 0, 0); idle(1);
        cur_req = "R6";  cyc(1, 1, 4'd0, 32'h0000_0001, 0, 0);
                         cyc(1, 1, 4'd5, 32'h55, 0, 0);
        cur_req = "R2";  idle(3);
        cur_req = "R8";  idle(10);
        cur_req = "R11"; cyc(1, 1, 4'd4, 32'hAA, 0, 0); cyc(1, 0, 4'd4, 0, 0, 0);
        cur_req = "R8";  cyc(1, 1, 4'd0, 32'h0000_0100, 0, 0); idle(3);
                         cyc(1, 1, 4'd0, 32'h0000_0400, 0, 0); idle(9);
        cur_req = "R9";  for (int i = 0; i < 3; i++) cyc(0, 0, 4'd0, 0, 1, 0);
                         cyc(1, 1, 4'd0, 32'h0000_0208, 0, 0);
                         for (int i = 0; i < 5; i++) cyc(0, 0, 4'd0, 0, 1, 0);
        cur_req = "R10"; for (int i = 0; i < 5; i++) cyc(0, 0, 4'd0, 0, 0, 1);
                         cyc(1, 1, 4'd0, 32'h0000_0204, 0, 0);
                         for (int i = 0; i < 4; i++) cyc(0, 0, 4'd0, 0, 1, 1);
                         idle(4);
        cur_req = "R3";  cyc(1, 1, 4'd0, 32'h0000_0004, 0, 0); idle(3);
                         cyc(1, 1, 4'd4, 32'h1, 0, 0);
        cur_req = "R2";  cyc(1, 1, 4'd0, 32'h0000_0200, 0, 0); idle(8);
        cur_req = "R3";  cyc(1, 1, 4'd0, 32'h0000_0201, 0, 0); idle(3);
        cur_req = "R7";  cyc(1, 0, 4'd7, 0, 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule